// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block is the configuration front end of a multi-function peripheral. Software sees only two byte-wide locations. A write to the first one loads an index. Reads and writes to the second one then reach the register that the index points at. The index stays put between data accesses, so one index write can serve any number of data reads or writes.

A few indices are global: a fixed chip identification byte, a revision byte, and a logical-device number register. A small set of further indices are banked. They address the activation register and the two base-address bytes of whichever logical device the device-number register selects. Each logical device keeps its own copy of these registers. The block drives each device's activation bit and 16-bit I/O base continuously, so the downstream function blocks (a GPIO unit and a temperature monitor in the default build) can decode their own address windows.

Top module: `cfg_index_port`

## Requirements
- R1: After reset the index, the device-number register, every activation bit, every base address and `rd_data` are all zero.
- R2: A write with `acc_offset`=0 loads the index from `acc_wdata`. A read with `acc_offset`=0 returns the current index.
- R3: Index 0x20 reads as the CHIP_ID parameter (default 0xE9). Writes to it have no effect.
- R4: Index 0x27 reads as the REVISION parameter (default 0x03). Writes to it have no effect.
- R5: Index 0x07 is an 8-bit read/write device-number register. The value 0x07 selects device 0 (GPIO) and 0x0E selects device 1 (temperature monitor).
- R6: Index 0x30 is the banked activation register. Bit 0 is stored and drives `dev_active[d]` of the selected device. Bits 7:1 read as zero.
- R7: Indices 0x60 and 0x61 are the banked base-address high and low bytes. They drive `dev_base[d*16 +: 16]` as {high, low}.
- R8: A banked write changes only the bank of the device currently selected. The other banks keep their values.
- R9: When the device-number register matches no device, the banked indices read as 0x00 and writes to them change no output.
- R10: Any index other than those above reads as 0x00, and writes to it change no output and no register.
- R11: Data accesses (`acc_offset`=1) never change the index, so repeated data reads return the same register.
- R12: Read data appears on `rd_data` on the clock edge that takes the read and holds until the next read. A write reaches `dev_active`/`dev_base` on the clock edge that takes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access strobe, one cycle per access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_offset | input | 1 | 0 = index location, 1 = data location |
| acc_wdata | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| dev_active | output | NUM_DEV | Activation bit per logical device |
| dev_base | output | 16*NUM_DEV | I/O base per logical device, device 0 in the low bits |

## Verification
Each access takes exactly one clock edge. A read result is registered on the edge that takes the read, and a write updates the index, device-number register or bank outputs on that same edge. Nothing is due later. The bench drives each access on a falling edge, holds it across one rising edge and samples on the next falling edge, halfway between edges. It also samples `rd_data` again after idle cycles to confirm that it holds, and samples the device outputs after each ignored write to show they did not move.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
   localparam int IDX_W = 8;
   localparam logic [IDX_W-1:0] IDX_DEVSEL  = 8'h07;
   localparam logic [IDX_W-1:0] IDX_CHIPID  = 8'h20;
   localparam logic [IDX_W-1:0] IDX_REV     = 8'h27;
   localparam logic [IDX_W-1:0] IDX_ACT     = 8'h30;
   localparam logic [IDX_W-1:0] IDX_BASE_HI = 8'h60;
   localparam logic [IDX_W-1:0] IDX_BASE_LO = 8'h61;

   function automatic logic is_bank_index(logic [IDX_W-1:0] idx);
      return (idx == IDX_ACT) || (idx == IDX_BASE_HI) || (idx == IDX_BASE_LO);
   endfunction
endpackage

// File: rtl/cfgp_index_latch.sv
module cfgp_index_latch
   import cfgp_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] load_val,
   output logic [IDX_W-1:0]  index_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)     index_q <= '0;
      else if (load)  index_q <= load_val[IDX_W-1:0];
   end

   // index only moves on an index-location write
   assert_index_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(index_q));
   assert_index_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> index_q == $past(load_val[IDX_W-1:0]));
endmodule

// File: rtl/cfgp_global_regs.sv
module cfgp_global_regs
   import cfgp_pkg::*;
#(
   parameter int               DATA_W   = 8,
   parameter logic [DATA_W-1:0] CHIP_ID  = 8'hE9,
   parameter logic [DATA_W-1:0] REVISION = 8'h03
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] devsel_q,
   output logic [DATA_W-1:0] rdata
);
   always_ff @(posedge clk) begin
      if (!rst_n)                           devsel_q <= '0;
      else if (wr_en && idx == IDX_DEVSEL)  devsel_q <= wdata;
   end

   always_comb begin
      unique case (idx)
         IDX_DEVSEL: rdata = devsel_q;
         IDX_CHIPID: rdata = CHIP_ID;
         IDX_REV:    rdata = REVISION;
         default:    rdata = '0;
      endcase
   end

   assert_devsel_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && idx == IDX_DEVSEL) |=> $stable(devsel_q));
endmodule

// File: rtl/cfgp_dev_bank.sv
module cfgp_dev_bank
   import cfgp_pkg::*;
#(
   parameter int                DATA_W = 8,
   parameter int                BASE_W = 16,
   parameter logic [DATA_W-1:0] DEV_ID = 8'h07
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] devsel,
   output logic              hit,
   output logic              active_q,
   output logic [BASE_W-1:0] base_q,
   output logic [DATA_W-1:0] rdata
);
   localparam int HALF = BASE_W / 2;

   logic bank_wr;
   assign hit     = (devsel == DEV_ID);
   assign bank_wr = wr_en && hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         base_q   <= '0;
      end else if (bank_wr) begin
         if (idx == IDX_ACT)     active_q            <= wdata[0];
         if (idx == IDX_BASE_HI) base_q[BASE_W-1:HALF] <= wdata[HALF-1:0];
         if (idx == IDX_BASE_LO) base_q[HALF-1:0]      <= wdata[HALF-1:0];
      end
   end

   always_comb begin
      rdata = '0;
      if (hit) begin
         unique case (idx)
            IDX_ACT:     rdata[0]        = active_q;
            IDX_BASE_HI: rdata[HALF-1:0] = base_q[BASE_W-1:HALF];
            IDX_BASE_LO: rdata[HALF-1:0] = base_q[HALF-1:0];
            default:     rdata           = '0;
         endcase
      end
   end

   // a bank not selected by the device number never moves
   assert_foreign_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (devsel != DEV_ID) |=> ($stable(active_q) && $stable(base_q)));
   assert_offbank_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !is_bank_index(idx) |=> ($stable(active_q) && $stable(base_q)));
endmodule

// File: rtl/cfg_index_port.sv
module cfg_index_port
   import cfgp_pkg::*;
#(
   parameter int                       DATA_W   = 8,
   parameter int                       BASE_W   = 16,
   parameter int                       NUM_DEV  = 2,
   parameter logic [NUM_DEV*8-1:0]     DEV_IDS  = {8'h0E, 8'h07},
   parameter logic [7:0]               CHIP_ID  = 8'hE9,
   parameter logic [7:0]               REVISION = 8'h03
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      acc_valid,
   input  logic                      acc_write,
   input  logic                      acc_offset,
   input  logic [7:0]                acc_wdata,
   output logic [7:0]                rd_data,
   output logic [NUM_DEV-1:0]        dev_active,
   output logic [NUM_DEV*16-1:0]     dev_base
);
   localparam int ID_W = 8;

   // elaboration checks
   if (DATA_W != 8)          begin : g_bad_dw   $error("DATA_W must be 8"); end
   if (BASE_W != 2 * DATA_W) begin : g_bad_bw   $error("BASE_W must be two data bytes"); end
   if (NUM_DEV < 1 || NUM_DEV > 8) begin : g_bad_nd $error("NUM_DEV out of range"); end
   for (genvar a = 0; a < NUM_DEV; a++) begin : g_uniq_a
      for (genvar b = a + 1; b < NUM_DEV; b++) begin : g_uniq_b
         if (DEV_IDS[a*ID_W +: ID_W] == DEV_IDS[b*ID_W +: ID_W]) begin : g_dup
            $error("device numbers must be distinct");
         end
      end
   end

   logic                 idx_load;
   logic                 data_wr;
   logic                 rd_take;
   logic [IDX_W-1:0]     index_q;
   logic [DATA_W-1:0]    devsel_q;
   logic [DATA_W-1:0]    glob_rdata;
   logic [NUM_DEV-1:0]   bank_hit;
   logic [DATA_W-1:0]    bank_rdata [NUM_DEV];
   logic [DATA_W-1:0]    data_rdata;

   assign idx_load = acc_valid && acc_write && !acc_offset;
   assign data_wr  = acc_valid && acc_write && acc_offset;
   assign rd_take  = acc_valid && !acc_write;

   cfgp_index_latch #(.DATA_W(DATA_W)) u_idx (
      .clk(clk), .rst_n(rst_n), .load(idx_load), .load_val(acc_wdata), .index_q(index_q));

   cfgp_global_regs #(.DATA_W(DATA_W), .CHIP_ID(CHIP_ID), .REVISION(REVISION)) u_glob (
      .clk(clk), .rst_n(rst_n), .wr_en(data_wr), .idx(index_q), .wdata(acc_wdata),
      .devsel_q(devsel_q), .rdata(glob_rdata));

   for (genvar d = 0; d < NUM_DEV; d++) begin : g_bank
      cfgp_dev_bank #(.DATA_W(DATA_W), .BASE_W(BASE_W),
                      .DEV_ID(DEV_IDS[d*ID_W +: ID_W])) u_bank (
         .clk(clk), .rst_n(rst_n), .wr_en(data_wr), .idx(index_q), .wdata(acc_wdata),
         .devsel(devsel_q), .hit(bank_hit[d]), .active_q(dev_active[d]),
         .base_q(dev_base[d*BASE_W +: BASE_W]), .rdata(bank_rdata[d]));
   end

   always_comb begin
      data_rdata = glob_rdata;
      for (int d = 0; d < NUM_DEV; d++) data_rdata = data_rdata | bank_rdata[d];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       rd_data <= '0;
      else if (rd_take) rd_data <= acc_offset ? data_rdata : index_q;
   end

   assert_rd_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_take |=> $stable(rd_data));
   assert_chip_id_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_take && acc_offset && index_q == IDX_CHIPID) |=> rd_data == CHIP_ID);
   assert_one_bank_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bank_hit));
   assert_index_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_take && !acc_offset) |=> rd_data == $past(index_q));
endmodule

// File: tb/tb_cfg_index_port.sv
`timescale 1ns/1ps
module tb_cfg_index_port;
   logic        clk = 0;
   logic        rst_n = 0;
   logic        acc_valid = 0, acc_write = 0, acc_offset = 0;
   logic [7:0]  acc_wdata = 0;
   logic [7:0]  rd_data;
   logic [1:0]  dev_active;
   logic [31:0] dev_base;

   int checks = 0, fails = 0;
   bit done = 0;

   always #2 clk = ~clk;

   cfg_index_port dut (.clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
      .acc_offset(acc_offset), .acc_wdata(acc_wdata), .rd_data(rd_data),
      .dev_active(dev_active), .dev_base(dev_base));

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic acc(bit wr, bit off, logic [7:0] d);
      @(negedge clk);
      acc_valid = 1; acc_write = wr; acc_offset = off; acc_wdata = d;
      @(negedge clk);
      acc_valid = 0; acc_write = 0; acc_wdata = 0;
   endtask

   task automatic wreg(logic [7:0] idx, logic [7:0] d);
      acc(1, 0, idx);
      acc(1, 1, d);
   endtask

   task automatic rreg(logic [7:0] idx, output logic [7:0] q);
      acc(1, 0, idx);
      acc(0, 1, 8'h00);
      q = rd_data;
   endtask

   task automatic t_reset;
      chk("R1 index", {24'h0, dut.index_q}, 0);
      chk("R1 rd_data", {24'h0, rd_data}, 0);
      chk("R1 active", {30'h0, dev_active}, 0);
      chk("R1 base", dev_base, 0);
   endtask

   task automatic t_globals;
      logic [7:0] q;
      rreg(8'h20, q); chk("R3 chip id", {24'h0, q}, 32'hE9);
      wreg(8'h20, 8'h11); rreg(8'h20, q); chk("R3 id write ignored", {24'h0, q}, 32'hE9);
      rreg(8'h27, q); chk("R4 revision", {24'h0, q}, 32'h03);
      wreg(8'h27, 8'h55); rreg(8'h27, q); chk("R4 rev write ignored", {24'h0, q}, 32'h03);
      rreg(8'h07, q); chk("R5 devsel reset", {24'h0, q}, 0);
      wreg(8'h07, 8'hA5); rreg(8'h07, q); chk("R5 devsel rw", {24'h0, q}, 32'hA5);
   endtask

   task automatic t_index;
      logic [7:0] q;
      acc(1, 0, 8'h5C); acc(0, 0, 8'h00);
      chk("R2 index readback", {24'h0, rd_data}, 32'h5C);
      acc(1, 0, 8'h20);
      acc(0, 1, 0); chk("R11 read 1", {24'h0, rd_data}, 32'hE9);
      acc(0, 1, 0); chk("R11 read 2", {24'h0, rd_data}, 32'hE9);
      acc(1, 1, 8'h33); acc(0, 0, 0);
      chk("R11 data write keeps index", {24'h0, rd_data}, 32'h20);
      repeat (3) @(negedge clk);
      chk("R12 rd_data holds", {24'h0, rd_data}, 32'h20);
      q = 0;
   endtask

   task automatic t_banks;
      logic [7:0] q;
      wreg(8'h07, 8'h07);
      acc(1, 0, 8'h30); acc(1, 1, 8'hFF);
      chk("R12 active same edge", {30'h0, dev_active}, 32'h1);
      acc(0, 1, 0); chk("R6 upper bits zero", {24'h0, rd_data}, 32'h01);
      wreg(8'h60, 8'h12); wreg(8'h61, 8'h34);
      chk("R7 dev0 base", {16'h0, dev_base[15:0]}, 32'h1234);
      chk("R8 dev1 untouched", {16'h0, dev_base[31:16]}, 0);
      wreg(8'h07, 8'h0E);
      rreg(8'h60, q); chk("R8 dev1 hi reads own bank", {24'h0, q}, 0);
      wreg(8'h30, 8'h01); wreg(8'h60, 8'hAB); wreg(8'h61, 8'hCD);
      chk("R8 dev1 base", {16'h0, dev_base[31:16]}, 32'hABCD);
      chk("R8 dev0 kept", {16'h0, dev_base[15:0]}, 32'h1234);
      chk("R6 both active", {30'h0, dev_active}, 32'h3);
      wreg(8'h30, 8'h00);
      chk("R6 dev1 deactivated", {30'h0, dev_active}, 32'h1);
      wreg(8'h07, 8'h07);
      rreg(8'h61, q); chk("R7 dev0 lo readback", {24'h0, q}, 32'h34);
   endtask

   task automatic t_unmatched;
      logic [7:0] q;
      wreg(8'h07, 8'h42);
      rreg(8'h30, q); chk("R9 act reads zero", {24'h0, q}, 0);
      rreg(8'h60, q); chk("R9 base reads zero", {24'h0, q}, 0);
      wreg(8'h30, 8'h01); wreg(8'h61, 8'h99);
      chk("R9 active unchanged", {30'h0, dev_active}, 32'h1);
      chk("R9 base unchanged", dev_base, 32'hABCD1234);
   endtask

   task automatic t_unimpl;
      logic [7:0] q;
      wreg(8'h07, 8'h07);
      wreg(8'h55, 8'h77);
      rreg(8'h55, q); chk("R10 unimpl reads zero", {24'h0, q}, 0);
      wreg(8'h31, 8'h01);
      chk("R10 outputs unchanged", dev_base, 32'hABCD1234);
      chk("R10 active unchanged", {30'h0, dev_active}, 32'h1);
      rreg(8'h07, q); chk("R10 devsel unchanged", {24'h0, q}, 32'h07);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_globals();
      t_index();
      t_banks();
      t_unmatched();
      t_unimpl();
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule